// File: doc/BRIEF.md
# Packed Average and Absolute-Difference Unit

This block is a purely combinational 128-bit SIMD datapath. It takes two packed vectors and splits them into independent lanes of 8, 16, 32 or 64 bits. In every lane it applies one of four operations: a truncating average, a rounding average, an absolute difference, or a sum of absolute values. A signedness select controls how the averages and the absolute difference read their operands.

The averages are formed from the two operands each halved by a one-bit right shift, plus a correction bit taken from the operands' least significant bits. Because of this, no lane needs a carry bit beyond its own width. The sum of absolute values always treats its operands as signed, and the result wraps at the lane width. The unit is meant to sit in an execution stage, with its output registered by the surrounding pipeline.

Top module: `pavg_absd_unit`

## Requirements
- R1: With op_sel = 2'b00, each lane result is floor((a+b)/2), computed exactly without overflow, for lane operands a and b.
- R2: With op_sel = 2'b01, each lane result is floor((a+b+1)/2), computed exactly without overflow.
- R3: When is_signed = 1, the averages and the absolute difference read lane operands as two's complement, and the halving shift is arithmetic. When is_signed = 0, they read the operands as unsigned, and the shift is logical.
- R4: With op_sel = 2'b10, each lane result is a−b if a > b and b−a otherwise, using the selected signedness for the comparison. The result is zero exactly when a equals b.
- R5: With op_sel = 2'b11, each lane result is |a|+|b| modulo 2^W with signed operands, whatever the value of is_signed.
- R6: In the sum of absolute values, the absolute value of the most negative lane value is that same value, because negation wraps. For example, min + 0 gives min.
- R7: lane_size selects the lane width: 2'b00 = 8 bits (16 lanes), 2'b01 = 16 (8 lanes), 2'b10 = 32 (4 lanes), 2'b11 = 64 (2 lanes). Lane k occupies bits [k*W +: W], and no carry or sign passes between lanes.
- R8: The output depends only on the present inputs. All-zero operands give an all-zero result in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vec_a | input | 128 | First packed operand vector |
| vec_b | input | 128 | Second packed operand vector |
| op_sel | input | 2 | Operation: 00 truncating avg, 01 rounding avg, 10 abs difference, 11 sum of abs values |
| lane_size | input | 2 | Lane width code: 00=8, 01=16, 10=32, 11=64 bits |
| is_signed | input | 1 | 1 = two's complement lanes for averages and abs difference |
| vec_y | output | 128 | Packed result vector |

## Verification
The byte-lane configuration is swept exhaustively over every operand pair in every mode and signedness. This exposes a logical shift used where an arithmetic one is needed, which gives a wrong average for negative pairs. It also exposes a correction bit built from AND where OR is needed, which turns rounding into truncation, and an absolute difference compared with the wrong signedness, which returns a huge wrapped value for mixed-sign operands. The wider lanes are driven with pairs drawn from zero, one, all ones, the most negative and most positive values and their neighbours, plus pseudo-random pairs. These catch carries leaking across lane boundaries and a wrong lane-size decode. A dedicated vector puts the most negative value through the sum of absolute values: a design that saturates there or widens the result would not return that value unchanged.

// File: rtl/pavg_pkg.sv
package pavg_pkg;

  localparam int unsigned VEC_W     = 128;
  localparam int unsigned MIN_LANE  = 8;
  localparam int unsigned NUM_SIZES = 4;

  typedef enum logic [1:0] {
    OP_AVG_TRUNC = 2'b00,
    OP_AVG_ROUND = 2'b01,
    OP_ABS_DIFF  = 2'b10,
    OP_ABS_SUM   = 2'b11
  } pavg_op_e;

  typedef enum logic [1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } pavg_size_e;

endpackage

// File: rtl/pavg_lane.sv
module pavg_lane
  import pavg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  pavg_op_e     op,
  input  logic         sgn,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] half_a, half_b;
  logic [W-1:0] lsb_and, lsb_or;
  logic [W-1:0] avg_dn, avg_up;
  logic         a_gt_b;
  logic [W-1:0] diff;
  logic [W-1:0] mag_a, mag_b, mag_sum;

  // Halving without widening: fill bit follows the signedness.
  always_comb begin
    half_a  = {sgn & a[W-1], a[W-1:1]};
    half_b  = {sgn & b[W-1], b[W-1:1]};
    lsb_and = {{(W-1){1'b0}}, a[0] & b[0]};
    lsb_or  = {{(W-1){1'b0}}, a[0] | b[0]};
    avg_dn  = half_a + half_b + lsb_and;
    avg_up  = half_a + half_b + lsb_or;
  end

  // Absolute difference with signedness-aware compare.
  always_comb begin
    if (sgn) a_gt_b = $signed(a) > $signed(b);
    else     a_gt_b = a > b;
    diff = a_gt_b ? (a - b) : (b - a);
  end

  // Sum of magnitudes: always signed, wraps at lane width.
  always_comb begin
    mag_a   = a[W-1] ? (ZERO - a) : a;
    mag_b   = b[W-1] ? (ZERO - b) : b;
    mag_sum = mag_a + mag_b;
  end

  always_comb begin
    unique case (op)
      OP_AVG_TRUNC: y = avg_dn;
      OP_AVG_ROUND: y = avg_up;
      OP_ABS_DIFF:  y = diff;
      OP_ABS_SUM:   y = mag_sum;
      default:      y = avg_dn;
    endcase
  end

  // Assertions guarding the lane arithmetic.
  always_comb begin
    if (sgn) begin
      a_r1_trunc_between_s: assert (!($signed(avg_dn) < $signed(a) && $signed(avg_dn) < $signed(b)) &&
                                    !($signed(avg_dn) > $signed(a) && $signed(avg_dn) > $signed(b)));
    end else begin
      a_r1_trunc_between_u: assert (!(avg_dn < a && avg_dn < b) && !(avg_dn > a && avg_dn > b));
    end
    a_r2_round_step: assert (avg_up == avg_dn + {{(W-1){1'b0}}, a[0] ^ b[0]});
    a_r4_diff_zero: assert ((diff == ZERO) == (a == b));
    a_r5_sum_parity: assert (mag_sum[0] == (a[0] ^ b[0]));
  end

endmodule

// File: rtl/pavg_group.sv
module pavg_group
  import pavg_pkg::*;
#(
  parameter int unsigned TOTAL_W = 128,
  parameter int unsigned W       = 8
) (
  input  logic [TOTAL_W-1:0] a,
  input  logic [TOTAL_W-1:0] b,
  input  pavg_op_e           op,
  input  logic               sgn,
  output logic [TOTAL_W-1:0] y
);

  localparam int unsigned LANES = TOTAL_W / W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pavg_lane #(.W(W)) u_lane (
      .a   (a[k*W +: W]),
      .b   (b[k*W +: W]),
      .op  (op),
      .sgn (sgn),
      .y   (y[k*W +: W])
    );
  end

endmodule

// File: rtl/pavg_absd_unit.sv
module pavg_absd_unit
  import pavg_pkg::*;
(
  input  logic [127:0] vec_a,
  input  logic [127:0] vec_b,
  input  logic [1:0]   op_sel,
  input  logic [1:0]   lane_size,
  input  logic         is_signed,
  output logic [127:0] vec_y
);

  pavg_op_e   op;
  logic [VEC_W-1:0] grp_y [NUM_SIZES];

  assign op = pavg_op_e'(op_sel);

  // One lane group per supported width; the size code picks one.
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    pavg_group #(.TOTAL_W(VEC_W), .W(MIN_LANE << s)) u_grp (
      .a   (vec_a),
      .b   (vec_b),
      .op  (op),
      .sgn (is_signed),
      .y   (grp_y[s])
    );
  end

  always_comb begin
    vec_y = grp_y[lane_size];
  end

  always_comb begin
    if (vec_a == '0 && vec_b == '0) begin
      a_r8_zero_in_zero_out: assert (vec_y == '0);
    end
  end

endmodule

// File: tb/pavg_absd_unit_test.sv
`timescale 1ns/1ps
module pavg_absd_unit_test;

  logic         clk;
  logic [127:0] vec_a, vec_b, vec_y;
  logic [1:0]   op_sel, lane_size;
  logic         is_signed;

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 0;
  logic [63:0] seed = 64'h0123_4567_89ab_cdef;

  pavg_absd_unit uut (
    .vec_a(vec_a), .vec_b(vec_b), .op_sel(op_sel),
    .lane_size(lane_size), .is_signed(is_signed), .vec_y(vec_y)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [63:0] next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [63:0] wmask(int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  // Arithmetic reference for one lane, in a wide signed domain.
  function automatic logic [63:0] lane_ref(int w, logic [1:0] op, bit s,
                                           logic [63:0] a, logic [63:0] b);
    logic [63:0] m = wmask(w);
    logic signed [65:0] ea, eb, r;
    bit rd_signed = s || (op == 2'b11);
    ea = $signed({2'b00, a & m});
    eb = $signed({2'b00, b & m});
    if (rd_signed && a[w-1]) ea = ea - (66'sd1 <<< w);
    if (rd_signed && b[w-1]) eb = eb - (66'sd1 <<< w);
    case (op)
      2'b00: r = (ea + eb) >>> 1;
      2'b01: r = (ea + eb + 66'sd1) >>> 1;
      2'b10: r = (ea > eb) ? (ea - eb) : (eb - ea);
      default: r = ((ea < 0) ? -ea : ea) + ((eb < 0) ? -eb : eb);
    endcase
    return r[63:0] & m;
  endfunction

  function automatic logic [127:0] vec_ref(logic [1:0] sz, logic [1:0] op, bit s,
                                           logic [127:0] a, logic [127:0] b);
    int w = 8 << sz;
    logic [127:0] y = '0;
    logic [63:0] m = wmask(w);
    for (int k = 0; k < 128 / w; k++) begin
      logic [63:0] la = 64'((a >> (k * w))) & m;
      logic [63:0] lb = 64'((b >> (k * w))) & m;
      y = y | (128'(lane_ref(w, op, s, la, lb)) << (k * w));
    end
    return y;
  endfunction

  task automatic apply(logic [1:0] sz, logic [1:0] op, bit s,
                       logic [127:0] a, logic [127:0] b, string tag);
    logic [127:0] exp;
    @(negedge clk);
    vec_a = a; vec_b = b; op_sel = op; lane_size = sz; is_signed = s;
    exp = vec_ref(sz, op, s, a, b);
    #5;
    n_vec++;
    if (vec_y !== exp) begin
      n_bad++;
      $display("FAIL %s size=%0d op=%0d sgn=%0d a=%h b=%h got=%h exp=%h",
               tag, sz, op, s, a, b, vec_y, exp);
    end
  endtask

  function automatic string op_tag(logic [1:0] op, bit s);
    if (op == 2'b11) return "R5";
    if (s) return "R3";
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [63:0] corner(int w, int i);
    logic [63:0] m = wmask(w);
    logic [63:0] mn = 64'd1 << (w - 1);
    case (i)
      0: return 64'd0;
      1: return 64'd1;
      2: return m;
      3: return mn;
      4: return mn - 64'd1;
      5: return mn + 64'd1;
      6: return 64'd2;
      default: return 64'h5A3C_96E1_0F78_C3A5 & m;
    endcase
  endfunction

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    vec_a = '0; vec_b = '0; op_sel = 2'b00; lane_size = 2'b00; is_signed = 0;

    // R8: idle all-zero inputs give zero in every mode
    for (int op = 0; op < 4; op++)
      apply(2'b00, 2'(op), 1'b1, '0, '0, "R8");

    // Exhaustive byte-lane sweep: every (a,b) pair in every mode, R1 R2 R3 R4 R5
    for (int op = 0; op < 4; op++)
      for (int s = 0; s < 2; s++)
        for (int v = 0; v < 4096; v++) begin
          logic [127:0] a = '0, b = '0;
          for (int i = 0; i < 16; i++) begin
            logic [15:0] p = 16'(v * 16 + i);
            a[i*8 +: 8] = p[15:8];
            b[i*8 +: 8] = p[7:0];
          end
          apply(2'b00, 2'(op), s[0], a, b, op_tag(2'(op), s[0]));
        end

    // Wider lanes: corner pairs packed across lanes, then random, R7
    for (int sz = 1; sz < 4; sz++) begin
      int w = 8 << sz;
      int nl = 128 / w;
      for (int op = 0; op < 4; op++)
        for (int s = 0; s < 2; s++) begin
          for (int p0 = 0; p0 < 64; p0 += nl) begin
            logic [127:0] a = '0, b = '0;
            for (int k = 0; k < nl; k++) begin
              int p = (p0 + k) % 64;
              a = a | (128'(corner(w, p / 8)) << (k * w));
              b = b | (128'(corner(w, p % 8)) << (k * w));
            end
            apply(2'(sz), 2'(op), s[0], a, b, "R7");
          end
          for (int r = 0; r < 150; r++)
            apply(2'(sz), 2'(op), s[0], {next_rand(), next_rand()},
                  {next_rand(), next_rand()}, "R7");
        end
    end

    // R6: most negative value through the sum of absolute values stays itself
    apply(2'b11, 2'b11, 1'b0, {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000}, '0, "R6");
    apply(2'b10, 2'b11, 1'b1, {4{32'h8000_0000}}, '0, "R6");
    if (vec_y !== {4{32'h8000_0000}}) begin
      n_bad++;
      $display("FAIL R6 got=%h exp=%h", vec_y, {4{32'h8000_0000}});
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule